// File: doc/BRIEF.md
# Serial Flash Status and Erase Command Responder

This block sits on the device side of a four-wire SPI link, mode 0, and answers a serial flash's status and whole-array erase commands. It oversamples SCK, chip select and MOSI with the local clock. It collects the command byte at the start of each chip-select frame and applies the command's effect when chip select rises. It holds a write-enable latch, a four-bit protection field and a busy flag, and it reports all three in one status byte.

A status-read frame returns the status byte MSB first. The byte repeats for as long as the host keeps clocking, and each repeat is refreshed with the current state. A whole-array erase is accepted only at the end of a frame that carried exactly one command byte. The write-enable latch must be set, no protection bit may be set, and no erase may already be running. When an erase is accepted the block sends a one-cycle pulse to a memory-clear stub. That stub fills the array with 0xFF. The block then stays busy for a fixed number of local clock cycles.

Top module: `spi_flash_cmd_resp`

## Requirements
- R1: After reset the status byte is 0x00, `miso_oe` is low and `erase_req` is low.
- R2: Command 0x05 returns the status byte MSB first. Its layout is bit 0 busy, bit 1 write-enable latch, bits 5:2 protection field, and bits 7:6 zero. The command is answered even while busy.
- R3: During a 0x05 frame the status byte repeats without limit until chip select rises. Each repeat reloads the current status.
- R4: `miso_oe` is high only during the data phase of a 0x05 frame. It is low during command bits, outside frames and after chip select rises.
- R5: A frame of exactly 8 bits carrying 0x06 sets the write-enable latch. One carrying 0x04 clears it.
- R6: A frame of exactly 16 bits carrying 0x01 and then a data byte copies data bits 5:2 into the protection field and clears the latch. It has effect only when the latch is set.
- R7: A frame of exactly 8 bits carrying 0x60 or 0xC7 raises `erase_req` for one clock and sets busy. This happens only when the latch is set, the protection field is zero and the block is not busy.
- R8: An erase command is ignored while any protection bit is set. The latch stays set.
- R9: An erase command is ignored while the write-enable latch is clear.
- R10: An erase frame whose bit count is not exactly 8 is discarded.
- R11: Busy stays set for ERASE_CYCLES clock cycles after `erase_req`. Then busy and the write-enable latch both clear.
- R12: While busy, every command except 0x05 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, valid when `miso_oe` is high |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| erase_req | output | 1 | One-cycle request to clear the array to 0xFF |

## Verification
The bench sends erase frames that fail each gate in turn: protection set, latch clear, and a nine-bit frame. A design that checked only the opcode would emit a pulse for these frames, and the pulse count would move. During busy it tries to clear the latch and to write the protection field. A design that did not lock out commands would show a changed status byte in the next read. One long status read spans the end of an erase. A design that latched the byte once per frame would keep showing busy to the end of the frame, and one that stopped after a single byte would drop `miso_oe`. The bench also scores a write-status attempt with the latch clear, which must leave the protection field at zero.

// File: rtl/spi_flash_cmd_resp.sv
module spi_flash_cmd_resp #(
  parameter int ERASE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  output logic erase_req
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_ERA_A = 8'h60;
  localparam logic [7:0] OP_ERA_B = 8'hC7;

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;
  logic [4:0] bitcnt;
  logic [15:0] shin;
  logic [7:0] op, out_sh, status;
  logic [2:0] out_idx;
  logic rd_mode, oe, wel, busy;
  logic [3:0] prot;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; mosi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire cs_lo = ~cs_q[1];
  wire cs_f = ~cs_q[1] & cs_q[2];
  wire cs_r = cs_q[1] & ~cs_q[2];
  wire sck_r = sck_q[1] & ~sck_q[2] & cs_lo;
  wire sck_f = ~sck_q[1] & sck_q[2] & cs_lo;
  wire din = mosi_q[1];
  wire [7:0] op_next = {shin[6:0], din};

  assign status = {2'b00, prot, wel, busy};

  wire is_erase = (op == OP_ERA_A) || (op == OP_ERA_B);
  wire end8 = cs_r && bitcnt == 5'd8 && !busy;
  wire erase_go = end8 && is_erase && wel && prot == 4'd0;
  wire wen_go = end8 && op == OP_WEN;
  wire wdis_go = end8 && op == OP_WDIS;
  wire wstat_go = cs_r && bitcnt == 5'd16 && op == OP_WSTAT && wel && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; shin <= '0; op <= '0; rd_mode <= 1'b0;
    end else if (cs_f) begin
      bitcnt <= '0; op <= '0; rd_mode <= 1'b0;
    end else if (cs_r) begin
      rd_mode <= 1'b0;
    end else if (sck_r) begin
      shin <= {shin[14:0], din};
      if (bitcnt != 5'h1F) bitcnt <= bitcnt + 5'd1;
      if (bitcnt == 5'd7) begin
        op <= op_next;
        rd_mode <= (op_next == OP_STAT);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oe <= 1'b0; out_sh <= '0; out_idx <= '0;
    end else if (cs_f || cs_r) begin
      oe <= 1'b0; out_idx <= '0;
    end else if (sck_f && rd_mode) begin
      oe <= 1'b1;
      out_idx <= out_idx + 3'd1;
      out_sh <= (out_idx == 3'd0) ? status : {out_sh[6:0], 1'b0};
    end

  assign miso = oe & out_sh[7];
  assign miso_oe = oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; erase_req <= 1'b0;
    end else begin
      erase_req <= erase_go;
      if (erase_go) begin
        busy <= 1'b1;
        cnt <= CW'(ERASE_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; prot <= '0;
    end else begin
      if (busy && cnt == '0) wel <= 1'b0;
      else if (wen_go) wel <= 1'b1;
      else if (wdis_go || wstat_go) wel <= 1'b0;
      if (wstat_go) prot <= shin[5:2];
    end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  a_r7_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ($past(wel) && $past(prot) == 4'd0 && !$past(busy)));
  a_r7_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> erase_req);
  a_r11_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  a_r12_prot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> prot == $past(prot));
  a_r4_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !cs_lo) |=> !miso_oe);
endmodule

// File: tb/sim_spi_flash_cmd_resp.sv
module sim_spi_flash_cmd_resp;
  localparam int EC = 2000;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, erase_req;
  int checks = 0, errors = 0, pulses = 0;
  logic data_phase = 1'b0;
  logic [8:0] expq[$];

  always #2 clk = ~clk;

  spi_flash_cmd_resp #(.ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .erase_req(erase_req));

  always @(posedge clk) if (rst_n && erase_req) pulses <= pulses + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_byte(input logic [7:0] v, input logic care);
    expq.push_back({care, v});
  endtask

  task automatic bit_out(input logic b);
    mosi = b;
    tick(HALF);
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [15:0] val, input int nb, input int rdb);
    cs_n = 1'b0;
    tick(4);
    for (int i = nb - 1; i >= 0; i--) bit_out(val[i]);
    if (rdb > 0) begin
      data_phase = 1'b1;
      for (int i = 0; i < 8 * rdb; i++) bit_out(1'b0);
    end
    tick(HALF);
    data_phase = 1'b0;
    cs_n = 1'b1;
    tick(HALF);
    check(miso_oe == 1'b0, "R4 oe after frame", miso_oe, 0);
  endtask

  task automatic read_status(input logic [7:0] exp);
    expect_byte(exp, 1'b1);
    frame(16'h0005, 8, 1);
  endtask

  logic [7:0] mon_sh;
  int mon_n = 0;
  always @(posedge sck) begin
    if (data_phase) begin
      check(miso_oe === 1'b1, "R4 oe in data phase", miso_oe, 1);
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (expq.size() == 0) check(1'b0, "R3 unexpected byte", mon_sh, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          if (e[8]) check(mon_sh == e[7:0], "R2/R3 status byte", mon_sh, e[7:0]);
        end
      end
    end else begin
      check(miso_oe === 1'b0, "R4 oe in command bits", miso_oe, 0);
    end
  end

  initial begin
    tick(200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    tick(5);
    check(miso_oe == 1'b0, "R1 oe at reset", miso_oe, 0);
    check(erase_req == 1'b0, "R1 erase_req at reset", erase_req, 0);
    rst_n = 1'b1;
    tick(5);
    read_status(8'h00);                       // R1 R2
    frame(16'h0006, 8, 0); read_status(8'h02); // R5 set
    frame(16'h0004, 8, 0); read_status(8'h00); // R5 clear
    frame(16'h013C, 16, 0); read_status(8'h00); // R6 no latch
    frame(16'h0006, 8, 0); frame(16'h0114, 16, 0);
    read_status(8'h14);                        // R6 written, latch cleared
    frame(16'h0006, 8, 0);
    p = pulses;
    frame(16'h00C7, 8, 0);
    check(pulses == p, "R8 erase with protection", pulses, p);
    read_status(8'h16);                        // R8 latch kept
    frame(16'h0000, 16, 0);
    frame(16'h0101, 16, 0);                    // clear protection, latch drops
    read_status(8'h00);
    p = pulses;
    frame(16'h0060, 8, 0);
    check(pulses == p, "R9 erase without latch", pulses, p);
    frame(16'h0006, 8, 0);
    frame(16'h00C0, 9, 0);
    check(pulses == p, "R10 nine-bit erase frame", pulses, p);
    read_status(8'h02);
    frame(16'h00C7, 8, 0);
    check(pulses == p + 1, "R7 erase C7 accepted", pulses, p + 1);
    frame(16'h013C, 16, 0);                    // R12 write-status while busy
    frame(16'h0004, 8, 0);                     // R12 latch-clear while busy
    expect_byte(8'h03, 1'b1); expect_byte(8'h03, 1'b1);
    frame(16'h0005, 8, 2);                     // R2 readable while busy, R12
    expect_byte(8'h03, 1'b1); expect_byte(8'h03, 1'b1);
    for (int i = 0; i < 7; i++) expect_byte(8'h00, 1'b0);
    for (int i = 0; i < 3; i++) expect_byte(8'h00, 1'b1);
    frame(16'h0005, 8, 12);                    // R3 R11 refresh across completion
    check(expq.size() == 0, "R3 all repeats delivered", expq.size(), 0);
    frame(16'h0006, 8, 0);
    p = pulses;
    frame(16'h0060, 8, 0);
    check(pulses == p + 1, "R7 erase 60 accepted", pulses, p + 1);
    read_status(8'h03);
    tick(EC + 50);
    read_status(8'h00);                        // R11 busy and latch cleared
    tick(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule